// File: doc/BRIEF.md
# Temperature Monitor Status and Alert Logic

This block holds the event status, the configuration byte and the interrupt pin logic of a multi-channel temperature monitor. A converter and limit comparators upstream deliver already-compared per-channel events (above high limit, below low limit, above critical limit, diode fault) plus a converter-busy level. The block latches each event into a per-channel detail register and derives a summary byte from those registers. From the summary and the configuration it drives two active-low pins: an interrupt pin and a critical-temperature pin.

Software reaches the block through a simple register bus with an address, a read strobe, a write strobe and write data. Read data is registered and appears the cycle after the strobe. Reading a detail register returns its contents and clears it in the same edge. Summary bits follow their detail registers, so they clear only when software reads the matching detail register. The configuration byte is visible at two addresses that share one storage. It selects masking, standby and the comparator use of the interrupt pin, and it drives the run control of the conversion engine.

Top module: `tmon_status_alert`

## Requirements
- R1: After reset every detail register, the summary byte and the configuration byte read 00h, alert_n and crit_n are 1 and conv_run is 1.
- R2: An event input bit i set on a clock edge sets bit i of its detail register: high-limit at 04h, low-limit at 05h, critical-limit at 06h, diode fault at 07h. Bits at and above NUM_CH read 0. A detail bit stays set until its register is read.
- R3: A read of a detail register returns its value on bus_rdata in the next cycle and clears it at that edge, except that any event bit arriving in the same cycle stays set.
- R4: The summary byte at 02h has bit 7 = adc_busy, bit 4 = any high-limit detail bit, bit 3 = any low-limit detail bit, bit 2 = any fault detail bit, bit 1 = any critical detail bit, and bits 6, 5, 0 = 0.
- R5: Reading the summary byte clears nothing.
- R6: The configuration byte is written at 03h or 09h into one storage, and the full byte reads back at either address.
- R7: With configuration bit 5 = 0 and bit 7 = 0, alert_n is 0 exactly when summary bit 4, 3 or 2 is set. adc_busy never drives it.
- R8: With configuration bit 5 = 0 and bit 7 = 1, alert_n stays 1 while the detail and summary registers still update.
- R9: With configuration bit 5 = 1, alert_n is 0 exactly when summary bit 1 is set, whatever bit 7 holds.
- R10: crit_n is 0 exactly when summary bit 1 is set, independent of the configuration.
- R11: conv_run equals the inverse of configuration bit 6 (0 = active, 1 = standby).
- R12: Writes to 02h, 04h to 07h or unmapped addresses change no state, and reads of unmapped addresses return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| evt_high | input | NUM_CH | Per-channel above-high-limit events |
| evt_low | input | NUM_CH | Per-channel below-low-limit events |
| evt_crit | input | NUM_CH | Per-channel above-critical-limit events |
| evt_fault | input | NUM_CH | Per-channel diode fault events |
| adc_busy | input | 1 | Converter busy level |
| alert_n | output | 1 | Interrupt pin, active low |
| crit_n | output | 1 | Critical-temperature pin, active low |
| conv_run | output | 1 | Run control for the conversion engine |

## Verification
The bench sweeps every channel pattern of every event kind and every combination of the mask, comparator and standby bits. A design that routed the wrong summary bit or let the critical event reach the interrupt pin in interrupt mode would miscompare on the pins. It reads a detail register in the very cycle a new event arrives, so a design that let the clear win would lose the new bit on the second read. It also writes to read-only and unmapped addresses and reads the summary twice. A design that aliased the configuration to only one address, cleared status on a summary read, or let busy raise an interrupt would show the wrong byte or pin level.

// File: rtl/tmon_pkg.sv
package tmon_pkg;

    localparam int DW = 8;
    localparam int AW = 8;
    localparam int NUM_KINDS = 4;

    localparam logic [AW-1:0] ADDR_SUMMARY  = 8'h02;
    localparam logic [AW-1:0] ADDR_CFG_A    = 8'h03;
    localparam logic [AW-1:0] ADDR_CFG_B    = 8'h09;
    localparam logic [AW-1:0] ADDR_DET_BASE = 8'h04;

    typedef enum logic [1:0] {
        KIND_HIGH  = 2'd0,
        KIND_LOW   = 2'd1,
        KIND_CRIT  = 2'd2,
        KIND_FAULT = 2'd3
    } evt_kind_e;

    typedef struct packed {
        logic       mask_all;
        logic       standby;
        logic       comparator;
        logic [4:0] spare;
    } cfg_t;

    typedef struct packed {
        logic       busy;
        logic [1:0] zero_hi;
        logic       high;
        logic       low;
        logic       fault;
        logic       crit;
        logic       zero_lo;
    } summary_t;

    function automatic logic [AW-1:0] det_addr(input int kind);
        return ADDR_DET_BASE + AW'(kind);
    endfunction

    function automatic logic is_cfg_addr(input logic [AW-1:0] a);
        return (a == ADDR_CFG_A) || (a == ADDR_CFG_B);
    endfunction

endpackage

// File: rtl/tmon_sticky_bank.sv
module tmon_sticky_bank #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] set_i,
    input  logic              clr_i,
    output logic [NUM_CH-1:0] bits_o
);
    logic [NUM_CH-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else begin
            // a new event in the clearing cycle survives
            bits_q <= (clr_i ? '0 : bits_q) | set_i;
        end
    end

    assign bits_o = bits_q;
endmodule

// File: rtl/tmon_cfg_reg.sv
module tmon_cfg_reg
    import tmon_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg_o
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= cfg_t'(wdata);
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/tmon_pin_ctrl.sv
module tmon_pin_ctrl (
    input  logic sum_high,
    input  logic sum_low,
    input  logic sum_fault,
    input  logic sum_crit,
    input  logic mask_all,
    input  logic comparator,
    input  logic standby,
    output logic alert_n,
    output logic crit_n,
    output logic conv_run
);
    logic irq_src;
    logic alert_on;

    always_comb begin
        irq_src = sum_high | sum_low | sum_fault;
        if (comparator) begin
            alert_on = sum_crit;
        end else begin
            alert_on = irq_src & ~mask_all;
        end
    end

    assign alert_n  = ~alert_on;
    assign crit_n   = ~sum_crit;
    assign conv_run = ~standby;
endmodule

// File: rtl/tmon_status_alert.sv
module tmon_status_alert
    import tmon_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [NUM_CH-1:0] evt_high,
    input  logic [NUM_CH-1:0] evt_low,
    input  logic [NUM_CH-1:0] evt_crit,
    input  logic [NUM_CH-1:0] evt_fault,
    input  logic              adc_busy,
    output logic              alert_n,
    output logic              crit_n,
    output logic              conv_run
);
    localparam int PAD = DW - NUM_CH;

    logic [NUM_CH-1:0] evt_vec  [NUM_KINDS];
    logic [NUM_CH-1:0] det_bits [NUM_KINDS];
    logic [NUM_KINDS-1:0] det_rd_hit;

    logic [NUM_CH-1:0] hi_det, lo_det, cr_det, ft_det;
    cfg_t     cfg;
    summary_t summary;
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] rdata_q;

    assign evt_vec[KIND_HIGH]  = evt_high;
    assign evt_vec[KIND_LOW]   = evt_low;
    assign evt_vec[KIND_CRIT]  = evt_crit;
    assign evt_vec[KIND_FAULT] = evt_fault;

    generate
        for (genvar k = 0; k < NUM_KINDS; k++) begin : g_bank
            assign det_rd_hit[k] = bus_rd && (bus_addr == det_addr(k));
            tmon_sticky_bank #(.NUM_CH(NUM_CH)) u_bank (
                .clk    (clk),
                .rst    (rst),
                .set_i  (evt_vec[k]),
                .clr_i  (det_rd_hit[k]),
                .bits_o (det_bits[k])
            );
        end
    endgenerate

    assign hi_det = det_bits[KIND_HIGH];
    assign lo_det = det_bits[KIND_LOW];
    assign cr_det = det_bits[KIND_CRIT];
    assign ft_det = det_bits[KIND_FAULT];

    tmon_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr && is_cfg_addr(bus_addr)),
        .wdata (bus_wdata),
        .cfg_o (cfg)
    );

    always_comb begin
        summary         = '0;
        summary.busy    = adc_busy;
        summary.high    = |hi_det;
        summary.low     = |lo_det;
        summary.fault   = |ft_det;
        summary.crit    = |cr_det;
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_SUMMARY) begin
            rd_mux = summary;
        end else if (is_cfg_addr(bus_addr)) begin
            rd_mux = cfg;
        end else begin
            for (int k = 0; k < NUM_KINDS; k++) begin
                if (bus_addr == det_addr(k)) begin
                    rd_mux = {{PAD{1'b0}}, det_bits[k]};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;

    tmon_pin_ctrl u_pins (
        .sum_high   (summary.high),
        .sum_low    (summary.low),
        .sum_fault  (summary.fault),
        .sum_crit   (summary.crit),
        .mask_all   (cfg.mask_all),
        .comparator (cfg.comparator),
        .standby    (cfg.standby),
        .alert_n    (alert_n),
        .crit_n     (crit_n),
        .conv_run   (conv_run)
    );
endmodule

// File: rtl/tmon_status_alert_chk.sv
module tmon_status_alert_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [NUM_CH-1:0] evt_high,
    input logic [NUM_CH-1:0] hi_det,
    input logic [NUM_CH-1:0] cr_det,
    input logic [7:0]        cfg_bits,
    input logic              alert_n,
    input logic              crit_n,
    input logic              conv_run
);
    logic rd_hi, cfg_wr;
    assign rd_hi  = bus_rd && (bus_addr == 8'h04);
    assign cfg_wr = bus_wr && ((bus_addr == 8'h03) || (bus_addr == 8'h09));

    p_sticky_set_r2: assert property (@(posedge clk) disable iff (rst)
        (evt_high != '0) |=> ((hi_det & $past(evt_high)) == $past(evt_high)));

    p_sticky_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_hi |=> ((hi_det & $past(hi_det)) == $past(hi_det)));

    p_read_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_hi && evt_high == '0) |=> (hi_det == '0));

    p_cfg_write_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (cfg_bits == $past(bus_wdata)));

    p_cfg_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> $stable(cfg_bits));

    p_mask_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_bits[7] && !cfg_bits[5]) |-> alert_n);

    p_comparator_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_bits[5] |-> (alert_n == (cr_det == '0)));

    p_crit_pin_r10: assert property (@(posedge clk) disable iff (rst)
        crit_n == (cr_det == '0));

    p_run_r11: assert property (@(posedge clk) disable iff (rst)
        conv_run == !cfg_bits[6]);
endmodule

bind tmon_status_alert tmon_status_alert_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .evt_high  (evt_high),
    .hi_det    (hi_det),
    .cr_det    (cr_det),
    .cfg_bits  (cfg),
    .alert_n   (alert_n),
    .crit_n    (crit_n),
    .conv_run  (conv_run)
);

// File: tb/tmon_status_alert_tb_top.sv
module tmon_status_alert_tb_top;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [NCH-1:0] evt_high = '0, evt_low = '0, evt_crit = '0, evt_fault = '0;
    logic adc_busy = 1'b0;
    logic alert_n, crit_n, conv_run;

    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmon_status_alert #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_high(evt_high),
        .evt_low(evt_low), .evt_crit(evt_crit), .evt_fault(evt_fault),
        .adc_busy(adc_busy), .alert_n(alert_n), .crit_n(crit_n), .conv_run(conv_run)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        tick();
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input int kind, input logic [NCH-1:0] pat);
        case (kind)
            0: evt_high = pat;
            1: evt_low = pat;
            2: evt_crit = pat;
            default: evt_fault = pat;
        endcase
        tick();
        evt_high = '0; evt_low = '0; evt_crit = '0; evt_fault = '0;
    endtask

    function automatic logic [7:0] sum_bit(input int kind);
        case (kind)
            0: return 8'h10;
            1: return 8'h08;
            2: return 8'h02;
            default: return 8'h04;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        #1;
        repeat (3) tick();
        rst = 1'b0;

        // R1 reset state
        chk("R1 alert_n", {7'd0, alert_n}, 8'h01);
        chk("R1 crit_n", {7'd0, crit_n}, 8'h01);
        chk("R1 conv_run", {7'd0, conv_run}, 8'h01);
        do_read(8'h02, d); chk("R1 summary", d, 8'h00);
        do_read(8'h03, d); chk("R1 cfg", d, 8'h00);
        for (int k = 0; k < 4; k++) begin
            do_read(8'h04 + 8'(k), d); chk("R1 detail", d, 8'h00);
        end

        // R2 R3 R4 R7 R10: every kind, every channel pattern
        for (int k = 0; k < 4; k++) begin
            for (int p = 1; p < 16; p++) begin
                pulse(k, NCH'(p));
                chk("R7 alert_n", {7'd0, alert_n}, (k == 2) ? 8'h01 : 8'h00);
                chk("R10 crit_n", {7'd0, crit_n}, (k == 2) ? 8'h00 : 8'h01);
                do_read(8'h02, d); chk("R4 summary", d, sum_bit(k));
                do_read(8'h04 + 8'(k), d); chk("R2 detail", d, 8'(p));
                do_read(8'h04 + 8'(k), d); chk("R3 cleared", d, 8'h00);
                do_read(8'h02, d); chk("R4 summary cleared", d, 8'h00);
                chk("R7 alert_n idle", {7'd0, alert_n}, 8'h01);
            end
        end

        // R3 event in the clearing cycle wins
        pulse(0, 4'b0001);
        evt_high = 4'b0010;
        do_read(8'h04, d);
        evt_high = '0;
        chk("R3 read value", d, 8'h01);
        do_read(8'h04, d); chk("R3 same-cycle event kept", d, 8'h02);
        do_read(8'h04, d); chk("R3 cleared after", d, 8'h00);

        // R5 summary read clears nothing
        pulse(1, 4'b1000);
        do_read(8'h02, d); chk("R5 first", d, 8'h08);
        do_read(8'h02, d); chk("R5 second", d, 8'h08);
        do_read(8'h05, d); chk("R5 detail intact", d, 8'h08);

        // R4 R7 busy
        adc_busy = 1'b1;
        tick();
        chk("R7 busy no alert", {7'd0, alert_n}, 8'h01);
        do_read(8'h02, d); chk("R4 busy bit", d, 8'h80);
        adc_busy = 1'b0;

        // R6 R11 config alias sweep
        for (int c = 0; c < 256; c++) begin
            do_write((c % 2 == 0) ? 8'h03 : 8'h09, 8'(c));
            do_read(8'h03, d); chk("R6 read 03", d, 8'(c));
            do_read(8'h09, d); chk("R6 read 09", d, 8'(c));
            chk("R11 conv_run", {7'd0, conv_run}, ((c >> 6) & 1) != 0 ? 8'h00 : 8'h01);
        end

        // R7 R8 R9 R10 R11 mode/mask sweep
        for (int m = 0; m < 8; m++) begin
            do_write(8'h09, 8'(m << 5));
            for (int k = 0; k < 4; k++) begin
                logic [7:0] ea;
                pulse(k, 4'b0100);
                if ((m & 1) != 0) ea = (k == 2) ? 8'h00 : 8'h01;
                else if ((m & 4) != 0) ea = 8'h01;
                else ea = (k == 2) ? 8'h01 : 8'h00;
                chk("R7 R8 R9 alert_n", {7'd0, alert_n}, ea);
                chk("R10 crit_n mode", {7'd0, crit_n}, (k == 2) ? 8'h00 : 8'h01);
                chk("R11 conv_run mode", {7'd0, conv_run}, ((m & 2) != 0) ? 8'h00 : 8'h01);
                do_read(8'h02, d); chk("R8 status updates", d, sum_bit(k));
                do_read(8'h04 + 8'(k), d); chk("R8 detail", d, 8'h04);
            end
        end

        // R12 writes to read-only/unmapped, unmapped reads
        do_write(8'h03, 8'h5A);
        do_write(8'h02, 8'hFF);
        for (int k = 0; k < 4; k++) do_write(8'h04 + 8'(k), 8'hFF);
        do_write(8'h00, 8'hFF);
        do_write(8'h0A, 8'hFF);
        do_write(8'hFF, 8'hFF);
        do_read(8'h02, d); chk("R12 summary", d, 8'h00);
        for (int k = 0; k < 4; k++) begin
            do_read(8'h04 + 8'(k), d); chk("R12 detail", d, 8'h00);
        end
        do_read(8'h09, d); chk("R12 cfg kept", d, 8'h5A);
        do_read(8'h00, d); chk("R12 unmapped 00", d, 8'h00);
        do_read(8'h08, d); chk("R12 unmapped 08", d, 8'h00);
        do_read(8'hFF, d); chk("R12 unmapped FF", d, 8'h00);

        finish_run();
    end
endmodule